// File: doc/BRIEF.md
# Programmable Bus Chip-Select and Termination Generator

This block drives one chip-select line and the matching transfer termination for an asynchronous 68k-style bus. A 16-bit option word sets everything it does: which access directions, byte lanes and function-code spaces may assert the select, whether the select follows the address strobe, the data strobe or a slow E-clock, and how many wait states pass before an internally generated acknowledge. An external comparator supplies the base-address match. Decoding the base address, assigning pins and running the interrupt-acknowledge cycle itself are left to the surrounding logic.

All inputs are sampled on the rising edge of the bus clock, and the outputs come from registers. The edge that first samples the address strobe asserted, after it was sampled negated, is called the start edge. A cycle opens at that edge only if the access qualifies. Once the cycle is open it holds until the address strobe is sampled negated. During an interrupt acknowledge whose level matches the programmed level, the block can raise an autovector request in place of the acknowledge.

Top module: `bus_select_gen`

## Requirements
- R1: After reset, and whenever the option word is zero, `cs_o`, `ack_o` and `avec_o` stay low.
- R2: A cycle opens only when `addr_hit_i` is 1 and the direction field (bits 12:11) allows the access: 00 never, 01 reads (`rd_i`=1) only, 10 writes only, 11 both.
- R3: The lane field (bits 14:13) must overlap the requested lanes in `lane_i` (bit 0 lower, bit 1 upper): 00 never, 01 lower, 10 upper, 11 either.
- R4: The space field (bits 5:4) must match `fc_i`: 00 needs code 7, 01 needs code 1 or 2, 10 needs code 5 or 6, and 11 needs any of 1, 2, 5 or 6.
- R5: Asynchronous mode is bit 15 = 0. With bit 10 = 0, `cs_o` is high after the start edge.
- R6: Asynchronous mode with bit 10 = 1: `cs_o` rises after the first edge, from the start edge on, that samples `ds_i` high.
- R7: Asynchronous mode with wait code n = 0..13 in bits 9:6: `ack_o` rises after edge start+2+n.
- R8: Wait code 14 terminates fast: `ack_o` rises after edge start+1.
- R9: Wait code 15 leaves termination to an external device, so `ack_o` and `avec_o` never rise.
- R10: After the first edge that samples `as_i` low, `cs_o`, `ack_o` and `avec_o` are all low.
- R11: A start needs `as_i` to have been sampled low before. A strobe already high when reset ends opens no cycle.
- R12: Synchronous mode is bit 15 = 1. `cs_o` rises after the first edge after the start edge that samples `eclk_en_i` high. `ack_o` rises after the next edge that samples `eclk_en_i` high while `cs_o` is high. Bit 10 and wait codes 0..14 have no effect in this mode.
- R13: If the start edge samples `iack_i`=1, `fc_i`=7, `iack_lvl_i` equal to bits 3:1, and bit 0 = 1, then `avec_o` rises in place of `ack_o`, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opt_i | input | 16 | Option word |
| addr_hit_i | input | 1 | Base-address match from external comparator |
| as_i | input | 1 | Address strobe, 1 = asserted |
| ds_i | input | 1 | Data strobe, 1 = asserted |
| rd_i | input | 1 | 1 = read, 0 = write |
| lane_i | input | 2 | Requested byte lanes, bit 0 lower, bit 1 upper |
| fc_i | input | 3 | Function code of the access |
| iack_i | input | 1 | Current cycle is an interrupt acknowledge |
| iack_lvl_i | input | 3 | Interrupt level being acknowledged |
| eclk_en_i | input | 1 | One-cycle E-clock timing enable |
| cs_o | output | 1 | Chip select, 1 = asserted |
| ack_o | output | 1 | Internal transfer acknowledge |
| avec_o | output | 1 | Autovector request |

## Verification
The assertions assume that the option word, direction, lanes, function code and interrupt inputs stay stable from the start edge until the address strobe is sampled low. They also assume that `eclk_en_i` is a pulse, not a level. The stimulus changes these inputs only while the strobe is low, and holds the strobe low for two cycles between accesses. It raises the E-clock enable for single cycles at fixed offsets from the start edge. The data strobe is raised at or after the address strobe and is dropped together with it.

// File: rtl/bsg_pkg.sv
`timescale 1ns/1ps
package bsg_pkg;
  localparam int CODE_W = 4;

  typedef struct packed {
    logic              sync_mode;
    logic [1:0]        lane_sel;
    logic [1:0]        dir_sel;
    logic              on_ds;
    logic [CODE_W-1:0] wait_code;
    logic [1:0]        space_sel;
    logic [2:0]        irq_lvl;
    logic              autovec;
  } sel_opt_t;

  localparam logic [CODE_W-1:0] WAIT_FAST = 4'hE;
  localparam logic [CODE_W-1:0] WAIT_EXT  = 4'hF;
  localparam logic [2:0]        FC_CPU    = 3'd7;

  function automatic logic space_ok(input logic [1:0] sel, input logic [2:0] fc);
    logic usr, sup;
    usr = (fc == 3'd1) || (fc == 3'd2);
    sup = (fc == 3'd5) || (fc == 3'd6);
    unique case (sel)
      2'b00:   space_ok = (fc == FC_CPU);
      2'b01:   space_ok = usr;
      2'b10:   space_ok = sup;
      default: space_ok = usr | sup;
    endcase
  endfunction
endpackage

// File: rtl/bsg_access_qual.sv
`timescale 1ns/1ps
module bsg_access_qual
  import bsg_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             addr_hit_i,
  input  logic             rd_i,
  input  logic [LANES-1:0] lane_i,
  input  logic [2:0]       fc_i,
  input  logic [1:0]       dir_sel_i,
  input  logic [LANES-1:0] lane_sel_i,
  input  logic [1:0]       space_sel_i,
  output logic             qual_o
);
  logic [LANES-1:0] lane_hit;
  logic             dir_ok;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_hit[l] = lane_sel_i[l] & lane_i[l];
  end

  // dir_sel bit 0 enables reads, bit 1 writes
  assign dir_ok = rd_i ? dir_sel_i[0] : dir_sel_i[1];
  assign qual_o = addr_hit_i & dir_ok & (|lane_hit) & space_ok(space_sel_i, fc_i);
endmodule

// File: rtl/bsg_cycle_ctl.sv
`timescale 1ns/1ps
module bsg_cycle_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic as_i,
  input  logic ds_i,
  input  logic eclk_en_i,
  input  logic qual_i,
  input  logic sync_i,
  input  logic on_ds_i,
  output logic start_o,
  output logic active_o,
  output logic cs_o
);
  logic armed_q, active_q, cs_q;
  logic cs_set;

  assign start_o = as_i & armed_q & qual_i;

  always_comb begin
    if (sync_i)       cs_set = active_q & eclk_en_i;
    else if (on_ds_i) cs_set = ds_i;
    else              cs_set = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      cs_q     <= 1'b0;
    end else if (!as_i) begin
      armed_q  <= 1'b1;
      active_q <= 1'b0;
      cs_q     <= 1'b0;
    end else begin
      if (armed_q) armed_q <= 1'b0;
      if (start_o) active_q <= 1'b1;
      if ((start_o | active_q) & cs_set) cs_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign cs_o     = cs_q;

  assert_cs_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !cs_o);
  assert_rearm_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !$past(as_i, 2));
  assert_qual_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(qual_i));
  assert_ds_timed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && on_ds_i && $rose(cs_q)) |-> $past(ds_i));
  assert_eclk_timed_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && $rose(cs_q)) |-> $past(eclk_en_i));
endmodule

// File: rtl/bsg_wait_timer.sv
`timescale 1ns/1ps
module bsg_wait_timer
  import bsg_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          as_i,
  input  logic          start_i,
  input  logic          sync_i,
  input  logic          eclk_en_i,
  input  logic          cs_i,
  input  logic [CW-1:0] code_i,
  output logic          term_o
);
  localparam int CNT_W = CW + 1;

  logic [CNT_W-1:0] cnt_q, load;
  logic             run_q, term_q;

  // fast code loads zero: terminate one edge after start
  assign load = (code_i == WAIT_FAST) ? '0 : {1'b0, code_i} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      term_q <= 1'b0;
    end else if (!as_i) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      term_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= load;
      run_q <= (code_i != WAIT_EXT);
    end else if (run_q) begin
      if (sync_i) begin
        if (cs_i && eclk_en_i) begin
          term_q <= 1'b1;
          run_q  <= 1'b0;
        end
      end else if (cnt_q == '0) begin
        term_q <= 1'b1;
        run_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign term_o = term_q;

  assert_term_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !term_o);
  assert_ext_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(term_o) |-> ($past(code_i) != WAIT_EXT));
  assert_fast_term_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !sync_i && code_i == WAIT_FAST) ##1 as_i |=> term_o);
endmodule

// File: rtl/bus_select_gen.sv
`timescale 1ns/1ps
module bus_select_gen
  import bsg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] opt_i,
  input  logic        addr_hit_i,
  input  logic        as_i,
  input  logic        ds_i,
  input  logic        rd_i,
  input  logic [1:0]  lane_i,
  input  logic [2:0]  fc_i,
  input  logic        iack_i,
  input  logic [2:0]  iack_lvl_i,
  input  logic        eclk_en_i,
  output logic        cs_o,
  output logic        ack_o,
  output logic        avec_o
);
  sel_opt_t opt;
  logic     qual, start, active, cs, term, iack_hit, iack_q;

  assign opt = sel_opt_t'(opt_i);

  bsg_access_qual #(.LANES(2)) u_qual (
    .addr_hit_i (addr_hit_i),
    .rd_i       (rd_i),
    .lane_i     (lane_i),
    .fc_i       (fc_i),
    .dir_sel_i  (opt.dir_sel),
    .lane_sel_i (opt.lane_sel),
    .space_sel_i(opt.space_sel),
    .qual_o     (qual)
  );

  bsg_cycle_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .as_i     (as_i),
    .ds_i     (ds_i),
    .eclk_en_i(eclk_en_i),
    .qual_i   (qual),
    .sync_i   (opt.sync_mode),
    .on_ds_i  (opt.on_ds),
    .start_o  (start),
    .active_o (active),
    .cs_o     (cs)
  );

  bsg_wait_timer #(.CW(CODE_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .as_i     (as_i),
    .start_i  (start),
    .sync_i   (opt.sync_mode),
    .eclk_en_i(eclk_en_i),
    .cs_i     (cs),
    .code_i   (opt.wait_code),
    .term_o   (term)
  );

  assign iack_hit = iack_i & (fc_i == FC_CPU) & (iack_lvl_i == opt.irq_lvl) & opt.autovec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    iack_q <= 1'b0;
    else if (start) iack_q <= iack_hit;
  end

  assign cs_o   = cs;
  assign ack_o  = term & ~iack_q;
  assign avec_o = term & iack_q;

  assert_avec_enabled_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avec_o) |-> $past(opt.autovec));
  assert_term_in_cycle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o || avec_o) |-> active);
endmodule

// File: tb/bus_select_gen_bench.sv
`timescale 1ns/1ps
module bus_select_gen_bench;
  typedef struct packed {
    logic [15:0] opt;
    logic        hit;
    logic        rd;
    logic [1:0]  lane;
    logic [2:0]  fc;
    logic        iack;
    logic [2:0]  lvl;
    logic [3:0]  dsd;
    logic [7:0]  emask;
    logic [4:0]  e_cs;
    logic [4:0]  e_ack;
    logic [4:0]  e_av;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 33;
  // e_* = negedge index after the start edge where the output is first seen high, 0 = never
  localparam vec_t VECS [NV] = '{
    '{16'h7810,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd7},  // R5 R7 zero wait
    '{16'h78D0,1,0,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd6,5'd0,4'd7},  // R7 three waits
    '{16'h7B50,1,1,2'b01,3'd2,0,3'd0,4'd0,8'h00,5'd1,5'd16,5'd0,4'd7}, // R7 thirteen waits
    '{16'h7B90,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd2,5'd0,4'd8},  // R8 fast
    '{16'h7BD0,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd0,5'd0,4'd9},  // R9 external
    '{16'h7810,0,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd2},  // R2 no address hit
    '{16'h6810,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd2},  // R2 read-only, read
    '{16'h6810,1,0,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd2},  // R2 read-only, write
    '{16'h7010,1,0,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd2},  // R2 write-only, write
    '{16'h7010,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd2},  // R2 write-only, read
    '{16'h6010,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd2},  // R2 direction off
    '{16'h3810,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd3},  // R3 lower, lower
    '{16'h3810,1,1,2'b10,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd3},  // R3 lower, upper
    '{16'h5810,1,1,2'b10,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd3},  // R3 upper, upper
    '{16'h5810,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd3},  // R3 upper, lower
    '{16'h5810,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd3},  // R3 upper, word
    '{16'h1810,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd3},  // R3 lanes off
    '{16'h7820,1,1,2'b01,3'd5,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd4},  // R4 supervisor hit
    '{16'h7820,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd4},  // R4 supervisor miss
    '{16'h7830,1,1,2'b01,3'd6,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd4},  // R4 either hit
    '{16'h7830,1,1,2'b01,3'd7,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd4},  // R4 either, cpu miss
    '{16'h7800,1,1,2'b01,3'd7,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd4},  // R4 cpu hit
    '{16'h7800,1,1,2'b01,3'd2,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd4},  // R4 cpu miss
    '{16'h7C10,1,0,2'b11,3'd1,0,3'd0,4'd2,8'h00,5'd3,5'd3,5'd0,4'd6},  // R6 late data strobe
    '{16'h7C10,1,0,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd1,5'd3,5'd0,4'd6},  // R6 early data strobe
    '{16'h780B,1,1,2'b01,3'd7,1,3'd5,4'd0,8'h00,5'd1,5'd0,5'd3,4'd13}, // R13 autovector
    '{16'h780B,1,1,2'b01,3'd7,1,3'd4,4'd0,8'h00,5'd1,5'd3,5'd0,4'd13}, // R13 level mismatch
    '{16'h780A,1,1,2'b01,3'd7,1,3'd5,4'd0,8'h00,5'd1,5'd3,5'd0,4'd13}, // R13 autovector off
    '{16'h7B8B,1,1,2'b01,3'd7,1,3'd5,4'd0,8'h00,5'd1,5'd0,5'd2,4'd13}, // R13 fast autovector
    '{16'hF810,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h44,5'd3,5'd7,5'd0,4'd12}, // R12 sync
    '{16'hFBD0,1,1,2'b01,3'd1,0,3'd0,4'd0,8'h44,5'd3,5'd0,5'd0,4'd12}, // R12 sync, external
    '{16'hFC10,1,1,2'b01,3'd1,0,3'd0,4'd5,8'h44,5'd3,5'd7,5'd0,4'd12}, // R12 sync ignores strobe select
    '{16'h0000,1,1,2'b11,3'd1,0,3'd0,4'd0,8'h00,5'd0,5'd0,5'd0,4'd1}   // R1 zero option word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opt = '0;
  logic        hit = 1'b0, as_s = 1'b0, ds_s = 1'b0, rd = 1'b0, iack = 1'b0, eclk = 1'b0;
  logic [1:0]  lane = '0;
  logic [2:0]  fc = '0, lvl = '0;
  logic        cs, ack, avec;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  bus_select_gen u_bus_select_gen (
    .clk_i(clk), .rst_ni(rst_n), .opt_i(opt), .addr_hit_i(hit),
    .as_i(as_s), .ds_i(ds_s), .rd_i(rd), .lane_i(lane), .fc_i(fc),
    .iack_i(iack), .iack_lvl_i(lvl), .eclk_en_i(eclk),
    .cs_o(cs), .ack_o(ack), .avec_o(avec)
  );

  task automatic check(input string what, input int rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int f_cs = 0, f_ack = 0, f_av = 0;
    @(negedge clk);
    as_s = 0; ds_s = 0; eclk = 0;
    opt = v.opt; hit = v.hit; rd = v.rd; lane = v.lane; fc = v.fc; iack = v.iack; lvl = v.lvl;
    @(negedge clk);
    @(negedge clk);
    as_s = 1; ds_s = (v.dsd == 0); eclk = v.emask[0];
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (cs   && f_cs  == 0) f_cs  = n;
      if (ack  && f_ack == 0) f_ack = n;
      if (avec && f_av  == 0) f_av  = n;
      if (n == int'(v.dsd)) ds_s = 1;
      eclk = (n < 8) ? v.emask[n] : 1'b0;
    end
    check($sformatf("vec %0d cs first", idx),   v.rq, f_cs,  v.e_cs);
    check($sformatf("vec %0d ack first", idx),  v.rq, f_ack, v.e_ack);
    check($sformatf("vec %0d avec first", idx), v.rq, f_av,  v.e_av);
    as_s = 0; ds_s = 0; eclk = 0;
    @(negedge clk);
    // R10 negation after strobe drop
    check($sformatf("vec %0d outputs after strobe drop", idx), 10, {cs, ack, avec}, 0);
  endtask

  initial begin
    // R1 reset state, with a qualifying access already presented
    opt = 16'h7810; hit = 1; rd = 1; lane = 2'b01; fc = 3'd1; as_s = 1;
    repeat (3) @(negedge clk);
    check("outputs in reset", 1, {cs, ack, avec}, 0);
    rst_n = 1;
    // R11 strobe high since reset: no cycle
    repeat (5) @(negedge clk);
    check("cs with strobe never seen low", 11, cs, 0);
    check("ack with strobe never seen low", 11, ack, 0);
    as_s = 0;
    @(negedge clk);
    as_s = 1;
    @(negedge clk);
    check("cs after re-arm", 11, cs, 1);
    repeat (2) @(negedge clk);
    check("ack after re-arm", 11, ack, 1);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule